// File: doc/BRIEF.md
# Banked Byte Memory with Run-Time Load Port

This block is a 4 KB byte-addressed memory for the instruction or data side of a 32-bit RISC-style core. It is built so that synthesis can map it onto block RAM. The storage is four byte-wide banks, so any access of one, two or four bytes at any byte address completes in one cycle. Before storage is indexed, the core's byte address has a fixed base subtracted from it, and the offset that results wraps within the 4 KB window. Read data is registered: it appears one clock after the address. A read enable freezes the output so that a fetch stage can stall.

Contents are not fixed at build time. While the core is held in reset, a separate load port streams in 32-bit words, one per cycle, starting at offset zero. The load port takes priority over core writes.

Top module: `bank_ram`

## Requirements
- R1: The value on `rdata` after a clock edge is the data at the address sampled at that edge, with one cycle of latency. The byte at the offset sits in bits 7:0 and the following bytes sit in ascending order (little-endian).
- R2: While `rst_n` is low at a clock edge, `rdata` becomes zero at that edge.
- R3: When `en` is low at an edge, `rdata` keeps its value. The next edge at which `en` is high updates it again.
- R4: `size` encodes the access width: 0 is a byte, 1 is a halfword, and 2 or 3 is a word. A read zero-fills the bits of `rdata` above the access width.
- R5: A write changes only the addressed bytes. They take the low bytes of `wdata` in ascending order, and all other bytes keep their contents.
- R6: The offset is `(addr - BASE_ADDR) mod DEPTH_BYTES`, with `BASE_ADDR` = 0x01000000. Any alignment is accepted, and an access that runs past the last byte continues at offset 0. Addresses that differ by a multiple of the depth alias.
- R7: In a write cycle, `rdata` returns the contents from before that write.
- R8: While `ld_valid` is high, one word of `ld_data` is stored per cycle at offsets 0, 4, 8 and onward. Byte 0 of the word goes to the lowest offset. A cycle with `ld_valid` low restarts the sequence at offset 0. Loading works while `rst_n` is low.
- R9: A core write in a cycle with `ld_valid` high has no effect on the memory.
- R10: Writes take effect regardless of `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the read output |
| addr | input | 32 | Byte address of the access |
| wdata | input | 32 | Write data, low bytes used first |
| size | input | 2 | Access width code (0 byte, 1 half, 2/3 word) |
| wr | input | 1 | 1 = write the addressed bytes, 0 = read only |
| en | input | 1 | Read enable; low holds `rdata` |
| ld_valid | input | 1 | Load word valid |
| ld_data | input | 32 | Load word |
| rdata | output | 32 | Registered read data |

## Verification
The hardest case to reach is an access that crosses the top of the window. It splits across the last and the first rows, so two banks use a row index one greater than the others, wrapped back to zero. The stimulus first fills the whole memory through the load port with a pattern in which every byte's value identifies its offset. It then reads and writes words and halfwords at offsets 0xFFE and 0xFFF, and reads back from offset 0. A second, short load burst is issued while a core write is pending. This shows both that the load pointer restarts and that the core write is dropped.

// File: rtl/bank_ram_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the banked byte memory: access-size codes and
// the number of byte lanes. Assumes a 32-bit data path.
package bank_ram_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_WALT = 2'd3
    } acc_size_e;

    // Number of bytes touched by an access of the given size code.
    function automatic logic [2:0] acc_bytes(input logic [1:0] sz);
        case (acc_size_e'(sz))
            ACC_BYTE: acc_bytes = 3'd1;
            ACC_HALF: acc_bytes = 3'd2;
            default:  acc_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/bank_ram_addr_map.sv
`timescale 1ns/1ps
// Address decoder: turns a core byte address into a row index per bank
// and the access byte number each bank serves. Assumes DEPTH is a power
// of two and that the offset wraps inside the window.
module bank_ram_addr_map
    import bank_ram_pkg::*;
#(
    parameter int          OFF_W     = 12,
    parameter logic [31:0] BASE_ADDR = 32'h0100_0000,
    localparam int         ROW_W     = OFF_W - 2
) (
    input  logic [31:0]                  addr,
    output logic [LANES-1:0][ROW_W-1:0]  row,
    output logic [LANES-1:0][1:0]        lane,
    output logic [1:0]                   lo
);

    logic [31:0]      rel;
    logic [ROW_W-1:0] base_row;
    logic             addr_unused;

    assign rel         = addr - BASE_ADDR;
    assign lo          = rel[1:0];
    assign base_row    = rel[OFF_W-1:2];
    assign addr_unused = ^rel[31:OFF_W];

    // Each bank serves byte (b - lo); banks below lo hold bytes of the next row.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane[b] = 2'(b) - lo;
        assign row[b]  = base_row + {{(ROW_W-1){1'b0}}, (2'(b) < lo)};
    end

endmodule

// File: rtl/bank_ram_bank.sv
`timescale 1ns/1ps
// One byte-wide bank with one write port and one registered read port.
// A read of the row being written returns the old byte. Only the output
// register is reset; the array has no reset, so it can map to block RAM.
module bank_ram_bank #(
    parameter int ROW_W = 10,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [ROW_W-1:0] waddr,
    input  logic [7:0]       wbyte,
    input  logic             re,
    input  logic [ROW_W-1:0] raddr,
    output logic [7:0]       q
);

    logic [7:0] mem [ROWS];

    // Store one byte per cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wbyte;
    end

    // Registered read, held while re is low, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= 8'h00;
        else if (re) q <= mem[raddr];
    end

endmodule

// File: rtl/bank_ram_loader.sv
`timescale 1ns/1ps
// Load pointer: one row per valid load word, starting at row 0. It is
// cleared by any cycle with ld_valid low and not by the core reset,
// because loading happens while the core is held in reset.
module bank_ram_loader #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             ld_valid,
    output logic [ROW_W-1:0] ld_row
);

    // Advance on each accepted word, restart when the stream pauses.
    always_ff @(posedge clk) begin
        if (!ld_valid) ld_row <= '0;
        else           ld_row <= ld_row + 1'b1;
    end

endmodule

// File: rtl/bank_ram_align.sv
`timescale 1ns/1ps
// Output alignment: rotates the registered bank bytes into little-endian
// order starting at the captured byte offset, then zero-fills above the
// captured access width. Purely combinational.
module bank_ram_align
    import bank_ram_pkg::*;
(
    input  logic [LANES-1:0][7:0] q,
    input  logic [1:0]            lo_q,
    input  logic [1:0]            size_q,
    output logic [31:0]           rdata
);

    logic [31:0] rot;

    // Byte k of the result comes from bank (lo_q + k).
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            rot[8*k +: 8] = q[2'(lo_q + 2'(k))];
        end
    end

    // Mask bits above the access width.
    always_comb begin
        case (acc_size_e'(size_q))
            ACC_BYTE: rdata = {24'h0, rot[7:0]};
            ACC_HALF: rdata = {16'h0, rot[15:0]};
            default:  rdata = rot;
        endcase
    end

endmodule

// File: rtl/bank_ram.sv
`timescale 1ns/1ps
// Banked byte memory: 4 byte-wide banks with a one-cycle registered read,
// sized writes at any byte alignment, a read enable that holds the output,
// and a load port that fills words from offset 0 with priority over core
// writes. Assumes DEPTH_BYTES is a power of two and at least 16.
module bank_ram
    import bank_ram_pkg::*;
#(
    parameter int          DEPTH_BYTES = 4096,
    parameter logic [31:0] BASE_ADDR   = 32'h0100_0000,
    localparam int         OFF_W       = $clog2(DEPTH_BYTES),
    localparam int         ROW_W       = OFF_W - 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    input  logic [1:0]  size,
    input  logic        wr,
    input  logic        en,
    input  logic        ld_valid,
    input  logic [31:0] ld_data,
    output logic [31:0] rdata
);

    logic [LANES-1:0][ROW_W-1:0] row;
    logic [LANES-1:0][1:0]       lane;
    logic [1:0]                  lo;
    logic [ROW_W-1:0]            ld_row;
    logic [LANES-1:0][7:0]       bank_q;
    logic [1:0]                  lo_q;
    logic [1:0]                  size_q;
    logic [2:0]                  nbytes;

    assign nbytes = acc_bytes(size);

    bank_ram_addr_map #(
        .OFF_W     (OFF_W),
        .BASE_ADDR (BASE_ADDR)
    ) map_i (
        .addr (addr),
        .row  (row),
        .lane (lane),
        .lo   (lo)
    );

    bank_ram_loader #(
        .ROW_W (ROW_W)
    ) load_i (
        .clk      (clk),
        .ld_valid (ld_valid),
        .ld_row   (ld_row)
    );

    // Per-bank write steering: the load word has priority over the core write.
    for (genvar b = 0; b < LANES; b++) begin : g_bank
        logic             core_we;
        logic             bank_we;
        logic [ROW_W-1:0] bank_waddr;
        logic [7:0]       bank_wbyte;
        logic [31:0]      wshift;

        assign wshift     = wdata >> {lane[b], 3'b000};
        assign core_we    = wr && ({1'b0, lane[b]} < nbytes);
        assign bank_we    = ld_valid || core_we;
        assign bank_waddr = ld_valid ? ld_row : row[b];
        assign bank_wbyte = ld_valid ? ld_data[8*b +: 8] : wshift[7:0];

        bank_ram_bank #(
            .ROW_W (ROW_W)
        ) bank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we),
            .waddr (bank_waddr),
            .wbyte (bank_wbyte),
            .re    (en),
            .raddr (row[b]),
            .q     (bank_q[b])
        );
    end

    // Capture offset and width alongside the bank read for the output rotate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= 2'd0;
            size_q <= 2'd0;
        end else if (en) begin
            lo_q   <= lo;
            size_q <= size;
        end
    end

    bank_ram_align align_i (
        .q      (bank_q),
        .lo_q   (lo_q),
        .size_q (size_q),
        .rdata  (rdata)
    );

endmodule

// File: rtl/bank_ram_chk.sv
`timescale 1ns/1ps
// Property checker for bank_ram, attached by bind. It observes only the
// ports of the block.
module bank_ram_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] addr,
    input logic [31:0] wdata,
    input logic [1:0]  size,
    input logic        wr,
    input logic        en,
    input logic        ld_valid,
    input logic [31:0] rdata
);

    // Stall: a low enable holds the output.
    assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rdata));

    // Byte reads are zero-filled above bit 7.
    assert_byte_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && size == 2'd0) |=> (rdata[31:8] == 24'h0));

    // Halfword reads are zero-filled above bit 15.
    assert_half_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && size == 2'd1) |=> (rdata[31:16] == 16'h0));

    // A word write is returned by an enabled word read of the same address
    // in the next cycle (R5, with the one-cycle latency of R1).
    assert_write_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && size == 2'd2 && !ld_valid) ##1
        (en && size == 2'd2 && !ld_valid && addr == $past(addr))
        |=> (rdata == $past(wdata, 2)));

endmodule

bind bank_ram bank_ram_chk chk_i (.*);

// File: tb/bank_ram_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench for bank_ram: full load in reset, a vector table of
// accesses, then directed stall, reload and reset cases.
module bank_ram_tb_top;

    localparam logic [31:0] B = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  size;
    logic        wr;
    logic        en;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bank_ram dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .size     (size),
        .wr       (wr),
        .en       (en),
        .ld_valid (ld_valid),
        .ld_data  (ld_data),
        .rdata    (rdata)
    );

    typedef struct packed {
        logic        w;
        logic [1:0]  sz;
        logic [31:0] a;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd2, 32'h0100_0000, 32'h0, 32'h0302_0100}, // R1 aligned word
        '{1'b0, 2'd2, 32'h0100_0101, 32'h0, 32'h0502_0300}, // R6 unaligned word
        '{1'b0, 2'd1, 32'h0100_0203, 32'h0, 32'h0000_0601}, // R4 half across rows
        '{1'b0, 2'd0, 32'h0100_0FFF, 32'h0, 32'h0000_00F0}, // R4 byte
        '{1'b0, 2'd2, 32'h0100_0FFE, 32'h0, 32'h0100_F0F1}, // R6 wrap read
        '{1'b1, 2'd2, 32'h0100_0010, 32'hDEAD_BEEF, 32'h1312_1110}, // R7 old data
        '{1'b0, 2'd2, 32'h0100_0010, 32'h0, 32'hDEAD_BEEF}, // R5 word write
        '{1'b1, 2'd0, 32'h0100_0011, 32'hFFFF_FFA5, 32'h0000_00BE}, // R7 byte
        '{1'b0, 2'd2, 32'h0100_0010, 32'h0, 32'hDEAD_A5EF}, // R5 byte write
        '{1'b1, 2'd1, 32'h0100_0013, 32'hFFFF_1234, 32'h0000_14DE}, // R7 half
        '{1'b0, 2'd2, 32'h0100_0011, 32'h0, 32'h1234_ADA5}, // R6 unaligned half write
        '{1'b0, 2'd2, 32'h0100_0010, 32'h0, 32'h34AD_A5EF}, // R5 neighbours kept
        '{1'b1, 2'd2, 32'h0100_0FFE, 32'h1122_3344, 32'h0100_F0F1}, // R6 wrap write
        '{1'b0, 2'd2, 32'h0100_0000, 32'h0, 32'h0302_1122}, // R6 wrapped bytes
        '{1'b0, 2'd1, 32'h0100_0FFF, 32'h0, 32'h0000_2233}, // R6 wrap half
        '{1'b0, 2'd2, 32'h0100_1010, 32'h0, 32'h34AD_A5EF}, // R6 alias
        '{1'b0, 2'd3, 32'h0100_0010, 32'h0, 32'h34AD_A5EF}  // R4 code 3 is a word
    };

    // Pattern byte for an offset: low byte xor the offset's upper nibble.
    function automatic logic [7:0] pat(input int o);
        logic [11:0] v;
        v = 12'(o);
        return v[7:0] ^ {4'h0, v[11:8]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs after a falling edge, return after the next.
    task automatic step(input logic w, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] d, input logic e);
        wr = w; size = sz; addr = a; wdata = d; en = e;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b1; wr = 1'b0; ld_valid = 1'b0;
        ld_data = '0; addr = B; wdata = '0; size = 2'd2;
        @(negedge clk);
        repeat (3) @(negedge clk);
        check("R2 reset output", rdata, 32'h0);

        // Fill all of memory through the load port while in reset.
        for (int i = 0; i < 1024; i++) begin
            ld_valid = 1'b1;
            ld_data  = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
            @(negedge clk);
        end
        ld_valid = 1'b0;
        check("R2 output during load", rdata, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].w, VEC[i].sz, VEC[i].a, VEC[i].d, 1'b1);
            check($sformatf("R1 table row %0d", i), rdata, VEC[i].exp);
        end

        // R3: hold while enable is low, then resume.
        step(1'b0, 2'd2, B, 32'h0, 1'b1);
        step(1'b0, 2'd2, B + 32'h100, 32'h0, 1'b0);
        step(1'b0, 2'd2, B + 32'h100, 32'h0, 1'b0);
        check("R3 held while stalled", rdata, 32'h0302_1122);
        step(1'b0, 2'd2, B + 32'h100, 32'h0, 1'b1);
        check("R3 resumes", rdata, 32'h0203_0001);

        // R10: a write with enable low still lands.
        step(1'b1, 2'd2, B + 32'h200, 32'hA1B2_C3D4, 1'b0);
        check("R3 held during write", rdata, 32'h0203_0001);
        step(1'b0, 2'd2, B + 32'h200, 32'h0, 1'b1);
        check("R10 write while stalled", rdata, 32'hA1B2_C3D4);

        // R8/R9: short reload restarts at offset 0, the core write is dropped.
        ld_valid = 1'b1; ld_data = 32'hCAFE_F00D;
        step(1'b1, 2'd2, B + 32'h800, 32'h9999_9999, 1'b0);
        ld_data = 32'h0BAD_C0DE;
        step(1'b1, 2'd2, B + 32'h800, 32'h9999_9999, 1'b0);
        ld_valid = 1'b0;
        step(1'b0, 2'd2, B, 32'h0, 1'b1);
        check("R8 reload word 0", rdata, 32'hCAFE_F00D);
        step(1'b0, 2'd2, B + 32'h4, 32'h0, 1'b1);
        check("R8 reload word 1", rdata, 32'h0BAD_C0DE);
        step(1'b0, 2'd2, B + 32'h800, 32'h0, 1'b1);
        check("R9 core write ignored", rdata, 32'h0B0A_0908);

        // R2: reset in mid-run clears the output.
        rst_n = 1'b0;
        step(1'b0, 2'd2, B + 32'h4, 32'h0, 1'b1);
        check("R2 reset mid-run", rdata, 32'h0);
        rst_n = 1'b1;
        step(1'b0, 2'd2, B + 32'h4, 32'h0, 1'b1);
        check("R1 read after reset", rdata, 32'h0BAD_C0DE);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule